// File: doc/BRIEF.md
# Page Access Rights and Fault Code Checker

This block sits after a page-table walker. It takes the attributes the walk has gathered for the final mapping: the user flag, the writable flag, the no-execute flag, the dirty flag and a 4-bit protection key. It also takes the kind of access being made, the privilege of the requester and the current paging mode flags. From these it works out which of read, write and execute the mapping grants. It then decides whether the requested access may proceed.

When the access is refused, the block builds the page-fault error code that the exception logic reports. It covers the write-protect rule, the rule against supervisor execution from user pages, the restricted supervisor data access to user pages, and the two protection-key rights registers. The walker also reports a missing entry or a reserved-bit violation, and the checker folds these into the same code. By default the three results pass through one register stage. A parameter can remove that stage and make the block purely combinational.

Top module: `page_rights_check`

## Requirements
- R1: A user-mode access (`usr_mode`=1) to a mapping whose user flag is clear is always refused. The error code then has bit 0 set and bit 5 clear, even when a protection key would also deny the access.
- R2: Read is granted unless the access is a supervisor access with `sup_no_user`=1 to a user page. When read is removed, write is removed too.
- R3: Write is granted when the writable flag is set. On a read-only page it is also granted to a supervisor access while `wp_on`=0.
- R4: Execute is granted only when the no-execute flag is clear. A supervisor fetch must also target a non-user page, unless `smep_on`=0.
- R5: Protection keys take effect only when `long_on`=1. A user page uses `ukey_rights` when `ukey_on`=1. A supervisor page uses `skey_rights` when `skey_on`=1. In every other case the keys have no effect.
- R6: For key k, bit 2k of the selected register removes read and write. Bit 2k+1 removes write, but only for user accesses or while `wp_on`=1. Execute is never changed by a key.
- R7: When the key rules alone refuse the requested access, error code bits 5 (key) and 0 (protection) are both set.
- R8: The error code layout is: bit 0 protection or reserved fault, bit 1 write access, bit 2 user access, bit 3 reserved fault. `walk_absent` gives a code with bit 0 and bit 3 clear, and it takes priority over `walk_rsvd`. `walk_rsvd` takes priority over the rights checks.
- R9: Bit 4 is set on a refused fetch only when either both `nxe_on` and `pae_on` are 1, or `smep_on`=1.
- R10: On an allowed access other than a write, the write right is withheld from `rights` while the dirty flag is clear.
- R11: `acc_kind` codes are 0 read, 1 write, 2 fetch, and 3 is treated as a read. `rights` is {execute, write, read}. The access is allowed when the rights bit for its code is set. On a refusal `rights` is 0. On an allowed access `err_code` is 0.
- R12: With `OUT_REG`=1, the outputs change one clock after the inputs. While `rst_n` is low, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output stage |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_kind | input | 2 | Access kind: 0 read, 1 write, 2 fetch |
| usr_mode | input | 1 | Requester runs at user privilege |
| sup_no_user | input | 1 | Supervisor data access that may not touch user pages |
| pte_user | input | 1 | Combined user flag of the mapping |
| pte_write | input | 1 | Combined writable flag |
| pte_noexec | input | 1 | Combined no-execute flag |
| pte_dirty | input | 1 | Dirty flag of the leaf entry |
| pte_key | input | KEY_W | Protection key of the leaf |
| walk_absent | input | 1 | Walk met a non-present entry |
| walk_rsvd | input | 1 | Walk met a reserved-bit violation |
| wp_on | input | 1 | Write protection for supervisor accesses |
| smep_on | input | 1 | Supervisor execution from user pages forbidden |
| nxe_on | input | 1 | No-execute feature enabled |
| pae_on | input | 1 | Wide page-table format in use |
| long_on | input | 1 | 64-bit mode active |
| ukey_on | input | 1 | User-page keys enabled |
| skey_on | input | 1 | Supervisor-page keys enabled |
| ukey_rights | input | 2*2**KEY_W | Key rights register for user pages |
| skey_rights | input | 2*2**KEY_W | Key rights register for supervisor pages |
| rights | output | 3 | Granted rights {exec, write, read} |
| allow | output | 1 | Requested access permitted |
| err_code | output | 6 | Page-fault error code |

## Verification
A single request can hit a base-rights refusal and a key refusal at once, and the code then has to show which rule took precedence. The vector table sets up this overlap on purpose. It sends a user access to a supervisor page whose key also denies the access, and the expected code has bit 0 without bit 5. It also sends a non-present walk that carries a reserved flag, and the expected code is zero while `allow` is low. Separately, cases where the key alone refuses must carry bit 5. A key write-disable on an allowed read must still strip the write right from `rights`.

// File: rtl/page_rights_check.sv
module page_rights_check #(
  parameter int KEY_W = 4,
  parameter bit OUT_REG = 1'b1,
  localparam int KREG_W = 2 * (1 << KEY_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        acc_kind,
  input  logic              usr_mode,
  input  logic              sup_no_user,
  input  logic              pte_user,
  input  logic              pte_write,
  input  logic              pte_noexec,
  input  logic              pte_dirty,
  input  logic [KEY_W-1:0]  pte_key,
  input  logic              walk_absent,
  input  logic              walk_rsvd,
  input  logic              wp_on,
  input  logic              smep_on,
  input  logic              nxe_on,
  input  logic              pae_on,
  input  logic              long_on,
  input  logic              ukey_on,
  input  logic              skey_on,
  input  logic [KREG_W-1:0] ukey_rights,
  input  logic [KREG_W-1:0] skey_rights,
  output logic [2:0]        rights,
  output logic              allow,
  output logic [5:0]        err_code
);

  logic is_wr, is_fx;
  logic [1:0] sel;
  logic base_r, base_w, base_x;
  logic [KREG_W-1:0] kreg;
  logic k_ad, k_wd;
  logic [2:0] k_mask, perm;
  logic user_hit, key_hit, perm_hit;
  logic c_fault, c_allow;
  logic [2:0] c_rights;
  logic [5:0] c_err;

  assign is_wr = (acc_kind == 2'd1);
  assign is_fx = (acc_kind == 2'd2);
  assign sel   = is_fx ? 2'd2 : (is_wr ? 2'd1 : 2'd0);

  assign base_r = ~(sup_no_user & ~usr_mode & pte_user);
  assign base_w = base_r & (pte_write | (~usr_mode & ~wp_on));
  assign base_x = ~pte_noexec & (usr_mode | ~(smep_on & pte_user));

  always_comb begin
    kreg = '0;
    if (long_on) begin
      if (pte_user) kreg = ukey_on ? ukey_rights : '0;
      else          kreg = skey_on ? skey_rights : '0;
    end
  end

  assign k_ad   = kreg[{pte_key, 1'b0}];
  assign k_wd   = kreg[{pte_key, 1'b1}] & (usr_mode | wp_on);
  assign k_mask = {1'b1, ~(k_ad | k_wd), ~k_ad};
  assign perm   = {base_x, base_w, base_r} & k_mask;

  assign user_hit = usr_mode & ~pte_user;
  assign key_hit  = ~k_mask[sel];
  assign perm_hit = ~perm[sel];

  assign c_fault = walk_absent | walk_rsvd | user_hit | perm_hit;
  assign c_allow = ~c_fault;

  always_comb begin
    c_err = '0;
    if (c_fault) begin
      c_err[0] = ~walk_absent & (walk_rsvd | user_hit | perm_hit);
      c_err[1] = is_wr;
      c_err[2] = usr_mode;
      c_err[3] = ~walk_absent & walk_rsvd;
      c_err[4] = is_fx & ((nxe_on & pae_on) | smep_on);
      c_err[5] = ~walk_absent & ~walk_rsvd & ~user_hit & key_hit;
    end
  end

  assign c_rights = c_fault ? 3'b000 : {perm[2], perm[1] & (pte_dirty | is_wr), perm[0]};

  generate
    if (OUT_REG) begin : g_reg
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          rights   <= '0;
          allow    <= 1'b0;
          err_code <= '0;
        end else begin
          rights   <= c_rights;
          allow    <= c_allow;
          err_code <= c_err;
        end
      end

      // R12
      reg_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (allow == $past(c_allow) && err_code == $past(c_err)));
    end else begin : g_comb
      assign rights   = c_rights;
      assign allow    = c_allow;
      assign err_code = c_err;
    end
  endgenerate

  // R1
  user_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (usr_mode && !pte_user && !walk_absent && !walk_rsvd) |-> (!c_allow && c_err[0] && !c_err[5]));

  // R7
  key_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    c_err[5] |-> (c_err[0] && !c_allow));

  // R9
  fetch_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    c_err[4] |-> (acc_kind == 2'd2));

  // R8
  absent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    walk_absent |-> (!c_allow && !c_err[0] && !c_err[3]));

  // R11
  allow_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    c_allow |-> (c_err == 6'd0));

  // R10
  dirty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (c_allow && !pte_dirty && acc_kind != 2'd1) |-> !c_rights[1]);

endmodule

// File: tb/page_rights_check_test.sv
module page_rights_check_test;

  localparam int KEY_W = 4;
  localparam int KREG_W = 2 * (1 << KEY_W);
  localparam int NV = 27;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] acc_kind = '0;
  logic usr_mode = 0, sup_no_user = 0, pte_user = 0, pte_write = 0, pte_noexec = 0, pte_dirty = 0;
  logic [KEY_W-1:0] pte_key = '0;
  logic walk_absent = 0, walk_rsvd = 0, wp_on = 0, smep_on = 0, nxe_on = 0, pae_on = 0;
  logic long_on = 0, ukey_on = 0, skey_on = 0;
  logic [KREG_W-1:0] ukey_rights = 32'h0000_0024;
  logic [KREG_W-1:0] skey_rights = 32'h0000_2300;
  logic [2:0] rights;
  logic allow;
  logic [5:0] err_code;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  page_rights_check #(.KEY_W(KEY_W), .OUT_REG(1'b1)) uut (
    .clk(clk), .rst_n(rst_n), .acc_kind(acc_kind), .usr_mode(usr_mode),
    .sup_no_user(sup_no_user), .pte_user(pte_user), .pte_write(pte_write),
    .pte_noexec(pte_noexec), .pte_dirty(pte_dirty), .pte_key(pte_key),
    .walk_absent(walk_absent), .walk_rsvd(walk_rsvd), .wp_on(wp_on),
    .smep_on(smep_on), .nxe_on(nxe_on), .pae_on(pae_on), .long_on(long_on),
    .ukey_on(ukey_on), .skey_on(skey_on), .ukey_rights(ukey_rights),
    .skey_rights(skey_rights), .rights(rights), .allow(allow), .err_code(err_code)
  );

  // row: acc,usr,rst,pu,prw,pnx,pd,key,miss,rsv,wp,smep,nxe,pae,lm,uke,ske | rights{x,w,r},allow,err
  localparam logic [30:0] VEC [NV] = '{
    {2'd0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b1,4'd0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 3'b111,1'b1,6'b000000}, // R2 R11 plain read
    {2'd0,1'b1,1'b0,1'b0,1'b1,1'b0,1'b1,4'd0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 3'b000,1'b0,6'b000101}, // R1
    {2'd0,1'b0,1'b1,1'b1,1'b1,1'b0,1'b1,4'd0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 3'b000,1'b0,6'b000001}, // R2 restricted read
    {2'd2,1'b0,1'b1,1'b1,1'b1,1'b0,1'b1,4'd0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 3'b100,1'b1,6'b000000}, // R2 fetch keeps exec
    {2'd1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,4'd0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 3'b111,1'b1,6'b000000}, // R3 wp off
    {2'd1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,4'd0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 3'b000,1'b0,6'b000011}, // R3 wp on
    {2'd1,1'b1,1'b0,1'b1,1'b0,1'b0,1'b1,4'd0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 3'b000,1'b0,6'b000111}, // R3 user ro
    {2'd2,1'b0,1'b0,1'b0,1'b1,1'b1,1'b1,4'd0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b1,1'b0,1'b0,1'b0, 3'b000,1'b0,6'b010001}, // R4 R9 nx
    {2'd2,1'b0,1'b0,1'b1,1'b1,1'b0,1'b1,4'd0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0, 3'b000,1'b0,6'b010001}, // R4 R9 smep
    {2'd2,1'b0,1'b0,1'b0,1'b1,1'b1,1'b1,4'd0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0, 3'b000,1'b0,6'b000001}, // R9 no I bit
    {2'd2,1'b1,1'b0,1'b1,1'b1,1'b0,1'b1,4'd0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0, 3'b111,1'b1,6'b000000}, // R4 user fetch
    {2'd0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,4'd0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 3'b101,1'b1,6'b000000}, // R10 read clean
    {2'd1,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,4'd0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 3'b111,1'b1,6'b000000}, // R10 write clean
    {2'd1,1'b1,1'b0,1'b1,1'b1,1'b0,1'b1,4'd0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 3'b000,1'b0,6'b000110}, // R8 absent
    {2'd0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b1,4'd0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 3'b000,1'b0,6'b001001}, // R8 reserved
    {2'd0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b1,4'd0,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 3'b000,1'b0,6'b000000}, // R8 absent over reserved
    {2'd0,1'b1,1'b0,1'b1,1'b1,1'b0,1'b1,4'd1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0, 3'b111,1'b1,6'b000000}, // R5 not long mode
    {2'd0,1'b1,1'b0,1'b1,1'b1,1'b0,1'b1,4'd1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b1,1'b0, 3'b000,1'b0,6'b100101}, // R6 R7 access-disable
    {2'd2,1'b1,1'b0,1'b1,1'b1,1'b0,1'b1,4'd1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b1,1'b0, 3'b100,1'b1,6'b000000}, // R6 exec untouched
    {2'd1,1'b1,1'b0,1'b1,1'b1,1'b0,1'b1,4'd2,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b1,1'b0, 3'b000,1'b0,6'b100111}, // R6 R7 write-disable
    {2'd0,1'b1,1'b0,1'b1,1'b1,1'b0,1'b1,4'd2,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b1,1'b0, 3'b101,1'b1,6'b000000}, // R6 read under wd
    {2'd0,1'b1,1'b0,1'b1,1'b1,1'b0,1'b1,4'd1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b1, 3'b111,1'b1,6'b000000}, // R5 wrong register
    {2'd0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b1,4'd4,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b1, 3'b000,1'b0,6'b100001}, // R5 R7 sup key
    {2'd1,1'b0,1'b0,1'b0,1'b1,1'b0,1'b1,4'd6,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b1, 3'b111,1'b1,6'b000000}, // R6 sup wd wp off
    {2'd1,1'b0,1'b0,1'b0,1'b1,1'b0,1'b1,4'd6,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b1,1'b0,1'b1, 3'b000,1'b0,6'b100011}, // R6 sup wd wp on
    {2'd3,1'b0,1'b0,1'b0,1'b1,1'b0,1'b1,4'd0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 3'b111,1'b1,6'b000000}, // R11 code 3
    {2'd0,1'b1,1'b0,1'b0,1'b1,1'b0,1'b1,4'd4,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b1, 3'b000,1'b0,6'b000101}  // R1 over key
  };

  task automatic drive(input logic [30:0] v);
    {acc_kind, usr_mode, sup_no_user, pte_user, pte_write, pte_noexec, pte_dirty, pte_key,
     walk_absent, walk_rsvd, wp_on, smep_on, nxe_on, pae_on, long_on, ukey_on, skey_on} = v[30:10];
  endtask

  task automatic expect_out(input string tag, input logic [9:0] exp);
    checks++;
    if ({rights, allow, err_code} !== exp) begin
      errors++;
      $display("FAIL %s: rights=%b allow=%b err=%b expected rights=%b allow=%b err=%b",
               tag, rights, allow, err_code, exp[9:7], exp[6], exp[5:0]);
    end
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    drive(VEC[0]);
    @(negedge clk);
    expect_out("R12 reset state", 10'b000_0_000000);
    @(negedge clk);
    expect_out("R12 reset holds", 10'b000_0_000000);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(VEC[i]);
      @(negedge clk);
      expect_out($sformatf("vector %0d", i), VEC[i][9:0]);
    end

    // R12: one-cycle latency
    @(negedge clk);
    drive(VEC[0]);
    @(negedge clk);
    expect_out("R12 settle", VEC[0][9:0]);
    drive(VEC[1]);
    #2;
    expect_out("R12 before edge", VEC[0][9:0]);
    @(negedge clk);
    expect_out("R12 after edge", VEC[1][9:0]);

    // R12: synchronous reset clears outputs
    drive(VEC[0]);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    expect_out("R12 reset again", 10'b000_0_000000);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule